// File: doc/BRIEF.md
# Latency-Configurable Dual-Port RAM

A single-clock memory with one write port and one read port. Parameters set the array geometry, the number of cycles a read takes to return data, the number of cycles a write takes to reach the array, and which value a read sees when it meets a write to the same address. The block suits pipelines that must match a fixed number of stages on either the write side or the read side. It also suits a design that has to model a memory macro with a given read-under-write behaviour.

A write request carries an enable, an address, data and a one-bit mask. It travels through `WR_LAT-1` register stages and then updates the array. A read request carries an enable and an address. With `RD_LAT` of zero the output follows the address combinationally. Otherwise the data is registered and appears `RD_LAT` cycles after the request. The output register keeps its value in any cycle where no enabled read completes. Array contents are not initialised. Reset clears only the pipeline control state and the output register.

The policy parameter `RUW` selects between two rules. With `"old"`, a registered read takes its data from the array at the clock edge that ends the request cycle, before any write that commits on that edge, and then carries that data down its pipeline. With `"new"`, the address goes down the pipeline instead, and the array is read at the last edge. A write that commits on that same edge to the same address is forwarded to the output.

Top module: `lat_ram`

## Requirements
- R1: Parameters set the geometry, with a default of 256 entries of 32 bits. A value written at any address, including the highest address, is returned unchanged over the full data width.
- R2: With `RD_LAT` ≥ 1, the data for a read presented in cycle t appears on `rd_data` during cycle t+`RD_LAT`, whatever pattern `rd_en` follows in the cycles in between.
- R3: With `RD_LAT` = 0, `rd_data` combinationally shows the array entry at `rd_addr`, including every write committed on an edge before the current cycle.
- R4: A write presented in cycle s updates the array on the clock edge that ends cycle s+`WR_LAT`-1.
- R5: A write with `wr_mask` = 0 leaves the array unchanged, even when `wr_en` is 1.
- R6: While `wr_en` is 0, nothing is written, whatever values `wr_addr` and `wr_data` carry.
- R7: Under `"old"` with `RD_LAT` ≥ 1, a read presented in cycle t returns the array contents as they stand before the edge that ends cycle t. A write committing on that edge is not seen.
- R8: Under `"new"` with `RD_LAT` ≥ 1, a read presented in cycle t returns the array contents at the edge that ends cycle t+`RD_LAT`-1, including a write to that address that commits on that same edge.
- R9: With `RD_LAT` ≥ 1, reset drives `rd_data` to 0 and cancels all pending reads and writes. Afterwards `rd_data` keeps its value in every cycle in which no enabled read completes.
- R10: When an address is written more than once, a later read returns the most recently committed value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low asynchronous reset of the pipelines and the output register |
| wr_en | input | 1 | Write request valid |
| wr_addr | input | $clog2(DEPTH) | Write address |
| wr_data | input | WIDTH | Write data |
| wr_mask | input | 1 | 1 lets the write update the array; 0 suppresses it |
| rd_en | input | 1 | Read request valid |
| rd_addr | input | $clog2(DEPTH) | Read address |
| rd_data | output | WIDTH | Read data |

## Verification
Six small instances (16 × 8) cover the latency pairs 0/1, 1/1, 2/2, 3/2 and 2/4 under both policies. All six receive the same stimulus. The bench then runs a pattern that fills every address, followed by directed writes that are masked or disabled, back-to-back double writes, and reads whose enable alternates, and finally a long pseudo-random stretch that is confined to a few addresses so that collisions happen often. For each read, the expected value is the latest unmasked write whose commit edge falls inside the window that the requirements define for that instance's latency and policy. Because of this, a read that collides with a write tells the two policies apart, and a commit that lands one edge late shows up as a stale value. A separate default-size instance checks the top address and the full 32-bit width.

// File: rtl/lat_ram.sv
`timescale 1ns/1ps
module lat_ram #(
  parameter int    DEPTH  = 256,
  parameter int    WIDTH  = 32,
  parameter int    RD_LAT = 1,
  parameter int    WR_LAT = 1,
  parameter string RUW    = "old"
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     wr_mask,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [WIDTH-1:0]         rd_data
);
  localparam int AW   = $clog2(DEPTH);
  localparam bit NEWP = (RUW == "new");

  if (RD_LAT < 0) begin : g_bad_rl
    $error("lat_ram: RD_LAT must be zero or more");
  end
  if (WR_LAT < 1) begin : g_bad_wl
    $error("lat_ram: WR_LAT must be one or more");
  end
  if (!(RUW == "new" || RUW == "old")) begin : g_bad_ruw
    $error("lat_ram: RUW must be \"old\" or \"new\"");
  end

  logic [WIDTH-1:0] mem [DEPTH];

  logic             c_en;
  logic [AW-1:0]    c_addr;
  logic [WIDTH-1:0] c_data;

  if (WR_LAT <= 1) begin : g_wdir
    assign c_en   = wr_en & wr_mask;
    assign c_addr = wr_addr;
    assign c_data = wr_data;
  end else begin : g_wpipe
    localparam int NS = WR_LAT - 1;
    logic [NS-1:0]    v;
    logic [AW-1:0]    a [NS];
    logic [WIDTH-1:0] d [NS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v <= '0;
      else begin
        v[0] <= wr_en & wr_mask;
        for (int i = 1; i < NS; i++) v[i] <= v[i-1];
      end
    end

    always_ff @(posedge clk) begin
      a[0] <= wr_addr;
      d[0] <= wr_data;
      for (int i = 1; i < NS; i++) begin
        a[i] <= a[i-1];
        d[i] <= d[i-1];
      end
    end

    assign c_en   = v[NS-1];
    assign c_addr = a[NS-1];
    assign c_data = d[NS-1];
  end

  always_ff @(posedge clk) begin
    if (c_en) mem[c_addr] <= c_data;
  end

  if (RD_LAT == 0) begin : g_rcomb
    assign rd_data = mem[rd_addr];
  end else begin : g_rseq
    localparam int NP = RD_LAT - 1;
    logic             fin_v;
    logic [WIDTH-1:0] fin_d;
    logic [WIDTH-1:0] q;

    if (NEWP) begin : g_new
      logic [AW-1:0] fin_a;
      if (NP == 0) begin : g_direct
        assign fin_v = rd_en;
        assign fin_a = rd_addr;
      end else begin : g_apipe
        logic [NP-1:0] pv;
        logic [AW-1:0] pa [NP];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pv <= '0;
          else begin
            pv[0] <= rd_en;
            for (int i = 1; i < NP; i++) pv[i] <= pv[i-1];
          end
        end
        always_ff @(posedge clk) begin
          pa[0] <= rd_addr;
          for (int i = 1; i < NP; i++) pa[i] <= pa[i-1];
        end
        assign fin_v = pv[NP-1];
        assign fin_a = pa[NP-1];
      end
      assign fin_d = (c_en && c_addr == fin_a) ? c_data : mem[fin_a];
    end else begin : g_old
      if (NP == 0) begin : g_direct
        assign fin_v = rd_en;
        assign fin_d = mem[rd_addr];
      end else begin : g_dpipe
        logic [NP-1:0]    pv;
        logic [WIDTH-1:0] pd [NP];
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pv <= '0;
          else begin
            pv[0] <= rd_en;
            for (int i = 1; i < NP; i++) pv[i] <= pv[i-1];
          end
        end
        always_ff @(posedge clk) begin
          pd[0] <= mem[rd_addr];
          for (int i = 1; i < NP; i++) pd[i] <= pd[i-1];
        end
        assign fin_v = pv[NP-1];
        assign fin_d = pd[NP-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (fin_v) q <= fin_d;
    end
    assign rd_data = q;
  end
endmodule

// File: rtl/lat_ram_chk.sv
`timescale 1ns/1ps
module lat_ram_chk #(
  parameter int    DEPTH  = 256,
  parameter int    WIDTH  = 32,
  parameter int    RD_LAT = 1,
  parameter int    WR_LAT = 1,
  parameter string RUW    = "old"
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [$clog2(DEPTH)-1:0] wr_addr,
  input logic [WIDTH-1:0]         wr_data,
  input logic                     wr_mask,
  input logic                     rd_en,
  input logic [$clog2(DEPTH)-1:0] rd_addr,
  input logic [WIDTH-1:0]         rd_data
);
  localparam bit NEWP = (RUW == "new");

  if (RD_LAT >= 1) begin : g_seq
    logic land;
    if (RD_LAT == 1) begin : g_l1
      assign land = rd_en;
    end else begin : g_ln
      logic [RD_LAT-2:0] sv;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sv <= '0;
        else begin
          sv[0] <= rd_en;
          for (int i = 1; i < RD_LAT-1; i++) sv[i] <= sv[i-1];
        end
      end
      assign land = sv[RD_LAT-2];
    end

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !land |=> $stable(rd_data));

    assert_rst_clear_R9: assert property (@(posedge clk)
      !rst_n |=> rd_data == '0);
  end

  if (RD_LAT == 1 && WR_LAT == 1) begin : g_unit
    // R8: same-edge forwarding under the new-data policy
    assert_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en && wr_mask && rd_addr == wr_addr)
        |=> (NEWP ? rd_data == $past(wr_data) : 1'b1));

    // R5: repeated read across a masked or absent write sees no change
    assert_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en) && rd_addr == $past(rd_addr)
        && !($past(wr_en) && $past(wr_mask))
        && (NEWP ? !(wr_en && wr_mask && wr_addr == rd_addr) : 1'b1))
        |=> $stable(rd_data));
  end
endmodule

bind lat_ram lat_ram_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .RUW(RUW)
) u_chk (.*);

// File: tb/tb_lat_ram.sv
`timescale 1ns/1ps
module tb_lat_ram;
  localparam int NC = 6;
  localparam int HM = 1024;
  localparam int RLS [NC] = '{0, 1, 1, 2, 3, 2};
  localparam int WLS [NC] = '{1, 1, 1, 2, 2, 4};
  localparam bit NWS [NC] = '{0, 0, 1, 0, 1, 1};

  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic       w_en = 0, w_mask = 0, r_en = 0;
  logic [3:0] w_addr = 0, r_addr = 0;
  logic [7:0] w_data = 0;
  logic [7:0] got [NC];

  for (genvar g = 0; g < NC; g++) begin : g_cfg
    lat_ram #(.DEPTH(16), .WIDTH(8), .RD_LAT(RLS[g]), .WR_LAT(WLS[g]),
              .RUW(NWS[g] ? "new" : "old")) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(w_en), .wr_addr(w_addr), .wr_data(w_data),
      .wr_mask(w_mask), .rd_en(r_en), .rd_addr(r_addr), .rd_data(got[g]));
  end

  logic        d_we = 0, d_wm = 0, d_re = 0;
  logic [7:0]  d_wa = 0, d_ra = 0;
  logic [31:0] d_wd = 0, d_q;
  lat_ram dut_def (
    .clk(clk), .rst_n(rst_n), .wr_en(d_we), .wr_addr(d_wa), .wr_data(d_wd),
    .wr_mask(d_wm), .rd_en(d_re), .rd_addr(d_ra), .rd_data(d_q));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  logic       hwe [HM], hwm [HM], hre [HM];
  logic [3:0] hwa [HM], hra [HM];
  logic [7:0] hwd [HM];
  string      htag [HM];
  logic [7:0] hold_v [NC];
  bit         hold_ok [NC];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp, input int g);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: cfg %0d cycle %0d got %0h expected %0h", req, g, cyc, act, exp);
    end
  endtask

  function automatic bit lookup(input int g, input int t, output logic [7:0] v);
    int lim = (NWS[g] && RLS[g] > 0) ? t + RLS[g] - 1 : t - 1;
    v = '0;
    for (int s = lim - WLS[g] + 1; s >= 0; s--)
      if (hwe[s] && hwm[s] && hwa[s] == hra[t]) begin
        v = hwd[s];
        return 1'b1;
      end
    return 1'b0;
  endfunction

  task automatic evaluate();
    for (int g = 0; g < NC; g++) begin
      int t = cyc - RLS[g];
      logic [7:0] v;
      string tg;
      if (t < 0) continue;
      if (hre[t]) begin
        tg = htag[t];
        if (tg == "") tg = (RLS[g] == 0) ? "R3" : (NWS[g] ? "R8" : "R7");
        if (lookup(g, t, v)) begin
          chk(got[g] === v, tg, got[g], v, g);
          hold_v[g] = v;
          hold_ok[g] = 1;
        end else hold_ok[g] = 0;
      end else if (RLS[g] > 0 && hold_ok[g]) begin
        chk(got[g] === hold_v[g], "R9", got[g], hold_v[g], g);
      end
    end
  endtask

  task automatic step(input bit we, input int wa, input int wd, input bit wm,
                      input bit re, input int ra, input string tg);
    @(negedge clk);
    w_en = we; w_addr = wa[3:0]; w_data = wd[7:0]; w_mask = wm;
    r_en = re; r_addr = ra[3:0];
    hwe[cyc] = we; hwa[cyc] = wa[3:0]; hwd[cyc] = wd[7:0]; hwm[cyc] = wm;
    hre[cyc] = re; hra[cyc] = ra[3:0]; htag[cyc] = tg;
    #1;
    evaluate();
    cyc++;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    for (int g = 0; g < NC; g++) begin hold_v[g] = 0; hold_ok[g] = 1; end
    repeat (3) @(negedge clk);
    // R9: reset value of registered outputs
    for (int g = 0; g < NC; g++)
      if (RLS[g] > 0) chk(got[g] === 8'h00, "R9", got[g], 0, g);
    chk(d_q === 32'h0, "R9", d_q, 0, 9);
    rst_n = 1;

    // R4: fill every address while reading the one written just before
    for (int a = 0; a < 16; a++) step(1, a, a * 7 + 3, 1, 1, (a + 15) % 16, "R4");
    step(0, 0, 0, 0, 0, 0, "R4");
    for (int a = 0; a < 16; a++) step(0, 0, 0, 0, 1, a, "R4");

    // R5: masked writes must not land
    step(1, 5, 8'hA5, 0, 1, 5, "R5");
    step(1, 6, 8'h5A, 0, 1, 5, "R5");
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 1, 5 + (k & 1), "R5");

    // R6: disabled writes with live address and data
    step(0, 7, 8'h3C, 1, 1, 7, "R6");
    step(0, 7, 8'hC3, 1, 1, 7, "R6");
    for (int k = 0; k < 5; k++) step(0, 7, k, 1, 1, 7, "R6");

    // R10: double write, later value wins
    step(1, 9, 8'h11, 1, 0, 0, "R10");
    step(1, 9, 8'h22, 1, 0, 0, "R10");
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 1, 9, "R10");

    // R2: alternating read enable with changing addresses
    for (int k = 0; k < 16; k++) step(0, 0, 0, 0, k % 2 == 0, (k * 5) % 16, "R2");
    for (int k = 0; k < 12; k++) step(0, 0, 0, 0, (k % 3) != 1, k, "R2");

    // R7/R8: colliding write and read on the same address
    for (int k = 0; k < 10; k++) step(1, 2, 8'h40 + k, 1, 1, 2, "");
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 1, 2, "");

    // pseudo-random mix concentrated on few addresses
    for (int k = 0; k < 320; k++) begin
      int wa, ra;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      wa = lf[8] ? {2'b00, lf[1:0]} : lf[3:0];
      ra = lf[9] ? {2'b00, lf[5:4]} : lf[7:4];
      step(lf[10], wa, {lf[15:11], lf[2:0]}, lf[12] | lf[13], lf[14] | lf[0], ra,
           (k % 2 == 0) ? "" : "R10");
    end
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0, 0, "R9");

    // R1: default geometry, highest address and full width
    @(negedge clk); d_we = 1; d_wm = 1; d_wa = 8'd255; d_wd = 32'hC0FFEE11;
    @(negedge clk); d_wa = 8'd0; d_wd = 32'h80000001; d_re = 1; d_ra = 8'd255;
    @(negedge clk); d_we = 0; d_ra = 8'd0;
    chk(d_q === 32'hC0FFEE11, "R1", d_q, 32'hC0FFEE11, 9);
    @(negedge clk); d_re = 0;
    chk(d_q === 32'h80000001, "R1", d_q, 32'h80000001, 9);
    @(negedge clk);
    chk(d_q === 32'h80000001, "R9", d_q, 32'h80000001, 9);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule